// File: doc/BRIEF.md
# Dual-Mode Serial Memory Streamer

This block reads a small byte array out over a single open-drain data line from the moment reset ends. A dedicated stream clock paces the transfer. The first nine rising edges of that clock are a synchronization preamble, and during them the line stays released. From the tenth rising edge on, each rising edge puts one new bit on the line. Each byte goes out most significant bit first, followed by one released null slot. The byte address then steps to the next location and wraps from the last location back to zero, with no end.

A second input carries the clock of a bidirectional bus. A qualified falling edge on it hands the line to a bidirectional controller for good: the streamer releases the line, ignores the stream clock from then on, and raises a mode flag. Only a reset brings the block back to streaming.

The array sits outside the block behind a combinational read port. The starting address is a design parameter and has no required value. All inputs are sampled on the system clock through synchronizers.

Top module: `ddc_stream_top`

## Requirements
- R1: After reset, `bidir_mode_o` is 0 and `sda_low_o` is 0 (line released).
- R2: During the first nine rising edges of `stream_clk_i` after reset, `sda_low_o` stays 0.
- R3: The tenth rising edge of `stream_clk_i` drives the first data bit, which is bit 7 of a byte. After that the line value changes only following a rising edge of the stream clock or a mode change.
- R4: A byte's eight data bits go out bit 7 first, down to bit 0. `sda_low_o` is 1 for a 0 bit and 0 for a 1 bit.
- R5: Each byte is followed by one null slot in which `sda_low_o` is 0.
- R6: Consecutive bytes come from consecutive addresses, and address DEPTH-1 (127) is followed by 0. `mem_addr_o` changes only by one step of that sequence. The first byte after reset comes from address START_ADDR.
- R7: The `scl_i` level is taken as high at reset. A low on `scl_i` that lasts fewer than FILT_LEN (3) system clocks after synchronization is ignored, and streaming continues unchanged.
- R8: A low on `scl_i` that lasts at least FILT_LEN system clocks sets `bidir_mode_o` within FILT_LEN+4 cycles. `sda_low_o` is 0 from the next cycle on.
- R9: While `bidir_mode_o` is 1, stream clock edges have no effect: `sda_low_o` stays 0 and `mem_addr_o` holds its value.
- R10: Once `bidir_mode_o` is set, no `scl_i` activity clears it. Only reset returns the block to streaming, and streaming then starts again with the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| stream_clk_i | input | 1 | Stream clock; a rising edge moves the stream by one slot |
| scl_i | input | 1 | Bidirectional bus clock, watched for a qualified falling edge |
| mem_rdata_i | input | WIDTH (8) | Byte read from the array at `mem_addr_o` |
| mem_addr_o | output | ADDR_W (7) | Address of the byte being streamed |
| sda_low_o | output | 1 | 1 pulls the open-drain data line low; 0 releases it |
| bidir_mode_o | output | 1 | 1 once the block has handed the line to the bidirectional controller |

## Verification
The bench drives the array with a one-to-one function of the address. It learns the start address from the first byte it receives and then streams more than a full lap, so the 127-to-0 wrap and every null slot are checked. Each preamble edge is checked on its own: a sequencer that counted eight or ten edges would pull the line early or drop the first bit 7. A bus clock low of two cycles must leave the stream untouched, which catches a filter that is too short. The real falling edge is placed while a zero bit is pulling the line, so a block that failed to release it, or that kept stepping on later stream edges, shows a low line or a moving address. A final reset must bring back both the preamble and the start byte, which catches a mode latch that does not clear on reset.

// File: rtl/ddc_stream_pkg.sv
package ddc_stream_pkg;

    // Sequencer phase: preamble edges, then the endless data stream
    typedef enum logic [0:0] {
        PH_SYNC = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // one flop chain per bit
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign q_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ddc_scl_qual.sv
module ddc_scl_qual #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    output logic mode_o
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
        logic             mode;
    } qual_state_t;

    qual_state_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (scl_s_i != qual_q.level) begin
            if (qual_q.cnt == CNT_W'(FILT_LEN - 1)) begin
                qual_d.level = scl_s_i;
                qual_d.cnt   = '0;
                // a filtered high-to-low step sets the one-way mode latch
                if (qual_q.level && !scl_s_i) begin
                    qual_d.mode = 1'b1;
                end
            end else begin
                qual_d.cnt = qual_q.cnt + 1'b1;
            end
        end else begin
            qual_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '{level: 1'b1, cnt: '0, mode: 1'b0};
        end else begin
            qual_q <= qual_d;
        end
    end

    assign mode_o = qual_q.mode;

endmodule

// File: rtl/ddc_stream_seq.sv
module ddc_stream_seq
    import ddc_stream_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int WIDTH      = 8,
    parameter int PRE_EDGES  = 9,
    parameter int START_ADDR = 93,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int SLOT_W    = $clog2(WIDTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              hold_i,
    input  logic [WIDTH-1:0]  rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drive_low_o,
    output phase_e            phase_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int PRE_W = $clog2(PRE_EDGES + 1);

    typedef struct packed {
        phase_e             phase;
        logic [PRE_W-1:0]   pre_cnt;
        logic [SLOT_W-1:0]  slot;
        logic [ADDR_W-1:0]  addr;
        logic               drive_low;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic [WIDTH-1:0] next_bits;

    always_comb begin
        seq_d     = seq_q;
        next_bits = rdata_i << (seq_q.slot + SLOT_W'(1));
        if (hold_i) begin
            seq_d.drive_low = 1'b0;
        end else if (rise_i) begin
            case (seq_q.phase)
                PH_SYNC: begin
                    if (seq_q.pre_cnt == PRE_W'(PRE_EDGES)) begin
                        seq_d.phase     = PH_DATA;
                        seq_d.slot      = '0;
                        seq_d.drive_low = ~rdata_i[WIDTH-1];
                    end else begin
                        seq_d.pre_cnt = seq_q.pre_cnt + 1'b1;
                    end
                end
                default: begin
                    if (seq_q.slot == SLOT_W'(WIDTH)) begin
                        // null slot done: first bit of the next byte
                        seq_d.slot      = '0;
                        seq_d.drive_low = ~rdata_i[WIDTH-1];
                    end else if (seq_q.slot == SLOT_W'(WIDTH - 1)) begin
                        // last data bit done: release for the null slot, step address
                        seq_d.slot      = SLOT_W'(WIDTH);
                        seq_d.drive_low = 1'b0;
                        seq_d.addr      = (seq_q.addr == ADDR_W'(DEPTH - 1))
                                          ? '0 : seq_q.addr + 1'b1;
                    end else begin
                        seq_d.slot      = seq_q.slot + 1'b1;
                        seq_d.drive_low = ~next_bits[WIDTH-1];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_SYNC, pre_cnt: '0, slot: '0,
                       addr: ADDR_W'(START_ADDR), drive_low: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_o      = seq_q.addr;
    assign drive_low_o = seq_q.drive_low;
    assign phase_o     = seq_q.phase;
    assign slot_o      = seq_q.slot;

endmodule

// File: rtl/ddc_stream_top.sv
module ddc_stream_top
    import ddc_stream_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int WIDTH       = 8,
    parameter int PRE_EDGES   = 9,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int START_ADDR  = 93,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_clk_i,
    input  logic              scl_i,
    input  logic [WIDTH-1:0]  mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              sda_low_o,
    output logic              bidir_mode_o
);

    localparam int SLOT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic sclk_prev;
    } edge_state_t;

    edge_state_t       edge_d, edge_q;
    logic [1:0]        sync_out;
    logic              sclk_s;
    logic              scl_s;
    logic              stream_rise;
    logic              mode_latched;
    phase_e            seq_phase;
    logic [SLOT_W-1:0] seq_slot;

    // bit 1: bus clock (idle high), bit 0: stream clock
    ddc_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, stream_clk_i}),
        .q_o   (sync_out)
    );

    assign sclk_s = sync_out[0];
    assign scl_s  = sync_out[1];

    always_comb begin
        edge_d           = edge_q;
        edge_d.sclk_prev = sclk_s;
        stream_rise      = sclk_s & ~edge_q.sclk_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '{sclk_prev: 1'b0};
        end else begin
            edge_q <= edge_d;
        end
    end

    ddc_scl_qual #(
        .FILT_LEN (FILT_LEN)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s_i (scl_s),
        .mode_o  (mode_latched)
    );

    ddc_stream_seq #(
        .DEPTH      (DEPTH),
        .WIDTH      (WIDTH),
        .PRE_EDGES  (PRE_EDGES),
        .START_ADDR (START_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (stream_rise),
        .hold_i      (mode_latched),
        .rdata_i     (mem_rdata_i),
        .addr_o      (mem_addr_o),
        .drive_low_o (sda_low_o),
        .phase_o     (seq_phase),
        .slot_o      (seq_slot)
    );

    assign bidir_mode_o = mode_latched;

endmodule

// File: rtl/ddc_stream_checker.sv
module ddc_stream_checker
    import ddc_stream_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int WIDTH  = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(WIDTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              scl_s_i,
    input  phase_e            phase_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [ADDR_W-1:0] mem_addr_o,
    input  logic              sda_low_o,
    input  logic              bidir_mode_o
);

    AST_PREAMBLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_SYNC) |-> !sda_low_o); // R2

    AST_CHANGE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low_o != $past(sda_low_o)) |-> ($past(rise_i) || $past(bidir_mode_o))); // R3

    AST_NULL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_DATA && slot_i == SLOT_W'(WIDTH)) |-> !sda_low_o); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr_o != $past(mem_addr_o)) |->
        (mem_addr_o == (($past(mem_addr_o) == ADDR_W'(DEPTH - 1)) ? ADDR_W'(0)
                        : ADDR_W'($past(mem_addr_o) + 1'b1)))); // R6

    AST_MODE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bidir_mode_o) |-> !$past(scl_s_i)); // R8

    AST_MODE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode_o |=> !sda_low_o); // R9

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode_o |=> bidir_mode_o); // R10

endmodule

bind ddc_stream_top ddc_stream_checker #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (stream_rise),
    .scl_s_i      (scl_s),
    .phase_i      (seq_phase),
    .slot_i       (seq_slot),
    .mem_addr_o   (mem_addr_o),
    .sda_low_o    (sda_low_o),
    .bidir_mode_o (bidir_mode_o)
);

// File: tb/ddc_stream_top_tb.sv
`timescale 1ns/1ps
module ddc_stream_top_tb;

    localparam int DEPTH    = 128;
    localparam int WIDTH    = 8;
    localparam int FILT_LEN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stream_clk = 1'b0;
    logic       scl = 1'b1;
    logic [6:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       sda_low;
    logic       bidir;

    int errors = 0;
    int checks = 0;
    logic last_low;
    int start_addr;

    always #4 clk = ~clk;

    // array content: one-to-one in the address, bit 7 always 0
    function automatic logic [7:0] content(input int a);
        return {1'b0, 7'(a)} ^ 8'h35;
    endfunction

    assign mem_rdata = content(int'(mem_addr));

    ddc_stream_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stream_clk_i (stream_clk),
        .scl_i        (scl),
        .mem_rdata_i  (mem_rdata),
        .mem_addr_o   (mem_addr),
        .sda_low_o    (sda_low),
        .bidir_mode_o (bidir)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one stream clock period; line sampled late in the high phase
    task automatic pulse();
        @(negedge clk) stream_clk = 1'b1;
        repeat (6) @(negedge clk);
        last_low = sda_low;
        stream_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic get_byte(output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            pulse();
            b = {b[6:0], ~last_low};
        end
        pulse();
        chk(last_low == 1'b0, "R5 null slot released", int'(last_low), 0);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] b;
        logic [6:0] held;
        do_reset();
        // R1 reset state
        chk(bidir == 1'b0, "R1 mode flag", int'(bidir), 0);
        chk(sda_low == 1'b0, "R1 line released", int'(sda_low), 0);

        // R2 preamble edges
        for (int i = 1; i <= 9; i++) begin
            pulse();
            chk(last_low == 1'b0, "R2 preamble released", int'(last_low), 0);
        end

        // R3 tenth edge starts with bit 7 (always 0 here, so line pulled)
        get_byte(b);
        chk(b[7] == 1'b0, "R3 first bit is bit 7", int'(b[7]), 0);
        start_addr = int'(7'(b ^ 8'h35));

        // R4 R6 more than a full lap, through the wrap
        for (int k = 1; k <= 130; k++) begin
            get_byte(b);
            chk(b == content((start_addr + k) % DEPTH), "R4 R6 byte order and wrap",
                int'(b), int'(content((start_addr + k) % DEPTH)));
        end

        // R7 short low on bus clock is filtered out
        @(negedge clk) scl = 1'b0;
        repeat (FILT_LEN - 1) @(negedge clk);
        scl = 1'b1;
        repeat (10) @(negedge clk);
        chk(bidir == 1'b0, "R7 glitch ignored", int'(bidir), 0);
        get_byte(b);
        chk(b == content((start_addr + 131) % DEPTH), "R7 stream continues",
            int'(b), int'(content((start_addr + 131) % DEPTH)));

        // R4 first bit of next byte is a 0: line pulled low
        pulse();
        chk(sda_low == 1'b1, "R4 zero bit pulls line", int'(sda_low), 1);

        // R8 qualified falling edge
        @(negedge clk) scl = 1'b0;
        repeat (FILT_LEN + 5) @(negedge clk);
        chk(bidir == 1'b1, "R8 mode switch", int'(bidir), 1);
        chk(sda_low == 1'b0, "R8 line released", int'(sda_low), 0);

        // R9 stream clock ignored
        held = mem_addr;
        for (int i = 0; i < 20; i++) begin
            pulse();
            chk(last_low == 1'b0, "R9 line stays released", int'(last_low), 0);
        end
        chk(mem_addr == held, "R9 address frozen", int'(mem_addr), int'(held));

        // R10 bus activity cannot leave the mode
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) scl = 1'b1;
            repeat (8) @(negedge clk);
            chk(bidir == 1'b1, "R10 mode sticky high scl", int'(bidir), 1);
            scl = 1'b0;
            repeat (8) @(negedge clk);
            chk(bidir == 1'b1, "R10 mode sticky low scl", int'(bidir), 1);
        end
        @(negedge clk) scl = 1'b1;

        // R10 reset restores streaming with preamble
        do_reset();
        chk(bidir == 1'b0, "R10 reset clears mode", int'(bidir), 0);
        for (int i = 1; i <= 9; i++) begin
            pulse();
            chk(last_low == 1'b0, "R10 preamble again", int'(last_low), 0);
        end
        get_byte(b);
        chk(b == content(start_addr), "R6 start byte after reset",
            int'(b), int'(content(start_addr)));

        summary();
    end

endmodule